// File: doc/BRIEF.md
# Accumulator Adder with Condition Flags and BCD Correction

This unit is the add path of a small accumulator CPU. It takes two operands, an operation code and a width select, together with the carry and half-carry flags the CPU currently holds. One clock edge later it presents a result and a fresh set of condition flags: half-carry, negative, zero, overflow and carry. It covers plain add and add-with-carry at byte and word width. It also covers the decimal correction that turns a binary byte sum into packed BCD after two BCD digits have been added.

Results are registered. A request presented with `in_valid` high on one rising edge appears on the outputs with `out_valid` high after that edge and stays there until the next edge. Subtract and compare, operand fetch and instruction decode sit outside this unit.

Top module: `alu_core`

## Requirements
- R1: An accepted request (in_valid high at a rising edge) produces out_valid high for exactly the following cycle; with in_valid low, out_valid is low next cycle. Reset (rst high at an edge) clears out_valid, result and every flag to 0.
- R2: op_sel 2'b00 (and the spare code 2'b11) adds without carry: at byte width result[7:0] = (a + b) mod 256 and flag_c = bit 8 of a + b, with c_flag_in ignored.
- R3: op_sel 2'b01 adds with carry: the sum is a + b + c_flag_in and flag_c is the carry out of the selected width.
- R4: At byte width flag_h = bit 4 of (a XOR b XOR sum). At word width (wide_sel = 1) flag_h equals h_flag_in.
- R5: flag_v is the top bit of (a XOR b XOR r XOR (r >> 1)), where r is the sum including its carry out: bit 7 of a 9-bit r at byte width, bit 15 of a 17-bit r at word width.
- R6: flag_n is the top bit of the result at the selected width and flag_z is set exactly when that truncated result is zero; byte-width results have result[15:8] = 0.
- R7: With wide_sel = 1, result = (a + b + carry) mod 65536 and flag_c = bit 16 of that sum.
- R8: op_sel 2'b10 applies BCD correction to a[7:0]; it adds 0x06 when the low nibble of a[7:0] is above 9 or h_flag_in is 1.
- R9: The BCD correction also adds 0x60 when the upper nibble is above 9, or c_flag_in is 1, or the upper nibble is above 8 while the low nibble is above 9; result = (a[7:0] + correction) mod 256.
- R10: After BCD correction flag_c = carry out of the corrected byte OR c_flag_in (never cleared), flag_n and flag_z follow the corrected byte, flag_v = 0, flag_h = h_flag_in, result[15:8] = 0, and opnd_b and wide_sel have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 00 add, 01 add with carry, 10 BCD correction, 11 add |
| wide_sel | input | 1 | 1 selects word width for the add operations |
| opnd_a | input | 16 | First operand; low byte is the accumulator for BCD correction |
| opnd_b | input | 16 | Second operand |
| h_flag_in | input | 1 | Current half-carry flag |
| c_flag_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 16 | Registered result |
| flag_h | output | 1 | Half-carry |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry |

## Verification
The only state is the output register, so an internal fault shows on the very next cycle after the request that caused it: a wrong sum bit, a flag taken from the wrong width, or a correction that misses one of its three high-nibble terms. Byte add-with-carry is driven over every operand pair with both carry values. BCD correction is driven over every accumulator value with all four flag combinations, with junk on the ignored inputs. Word adds cover the sign and carry boundaries and a pseudo-random spread. A scoreboard compares every flag of every result against a model written from the requirements, so one bad bit is reported in the cycle it appears.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_ADC     = 2'b01,
        OP_DADJ    = 2'b10,
        OP_ADD_ALT = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } alu_flags_t;

    localparam int BCD_DIGIT_MAX = 9;

    // Digit value above the largest legal BCD digit.
    function automatic logic digit_over(input logic [3:0] d, input int limit);
        return ({28'd0, d} > limit[31:0]);
    endfunction

endpackage

// File: rtl/alu_add.sv
module alu_add
    import alu_pkg::*;
#(
    parameter int W    = 8,
    parameter int HBIT = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output alu_flags_t   fl
);
    logic [W:0]   r;
    logic [W:0]   vx;
    logic [W-1:0] hx;

    always_comb begin
        r   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        vx  = {1'b0, a} ^ {1'b0, b} ^ r ^ (r >> 1);
        hx  = a ^ b ^ r[W-1:0];
        sum = r[W-1:0];
        fl.h = hx[HBIT];
        fl.v = vx[W-1];
        fl.c = r[W];
        fl.n = r[W-1];
        fl.z = (r[W-1:0] == '0);
    end

endmodule

// File: rtl/alu_dadj.sv
module alu_dadj
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] acc,
    input  logic         h_in,
    input  logic         c_in,
    output logic [W-1:0] res,
    output alu_flags_t   fl
);
    localparam int NW = W / 2;

    logic [3:0]   lo_dig;
    logic [3:0]   hi_dig;
    logic         fix_lo;
    logic         fix_hi;
    logic [W-1:0] corr;
    logic [W:0]   s;

    always_comb begin
        lo_dig = acc[3:0];
        hi_dig = acc[NW+3:NW];
        fix_lo = digit_over(lo_dig, BCD_DIGIT_MAX) || h_in;
        fix_hi = digit_over(hi_dig, BCD_DIGIT_MAX) || c_in ||
                 (digit_over(hi_dig, BCD_DIGIT_MAX - 1) && digit_over(lo_dig, BCD_DIGIT_MAX));
        corr = '0;
        if (fix_lo) corr[3:0]       = 4'h6;
        if (fix_hi) corr[NW+3:NW]   = 4'h6;
        s    = {1'b0, acc} + {1'b0, corr};
        res  = s[W-1:0];
        fl.h = h_in;
        fl.v = 1'b0;
        fl.c = s[W] | c_in;
        fl.n = s[W-1];
        fl.z = (s[W-1:0] == '0);
    end

endmodule

// File: rtl/alu_outreg.sv
module alu_outreg
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_d,
    input  logic [W-1:0] res_d,
    input  alu_flags_t   fl_d,
    output logic         vld_q,
    output logic [W-1:0] res_q,
    output alu_flags_t   fl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
            fl_q  <= '0;
        end else begin
            vld_q <= vld_d;
            if (vld_d) begin
                res_q <= res_d;
                fl_q  <= fl_d;
            end
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          op_sel,
    input  logic                wide_sel,
    input  logic [2*BYTE_W-1:0] opnd_a,
    input  logic [2*BYTE_W-1:0] opnd_b,
    input  logic                h_flag_in,
    input  logic                c_flag_in,
    output logic                out_valid,
    output logic [2*BYTE_W-1:0] result,
    output logic                flag_h,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_v,
    output logic                flag_c
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int HALF_B = BYTE_W / 2;

    alu_op_e             op;
    logic                carry_use;
    logic [BYTE_W-1:0]   n_sum;
    logic [WORD_W-1:0]   w_sum;
    logic [BYTE_W-1:0]   d_res;
    alu_flags_t          n_fl, w_fl, d_fl, mux_fl, q_fl;
    logic [WORD_W-1:0]   mux_res;

    assign op        = alu_op_e'(op_sel);
    assign carry_use = (op == OP_ADC) && c_flag_in;

    alu_add #(.W(BYTE_W), .HBIT(HALF_B)) u_add_byte (
        .a   (opnd_a[BYTE_W-1:0]),
        .b   (opnd_b[BYTE_W-1:0]),
        .cin (carry_use),
        .sum (n_sum),
        .fl  (n_fl)
    );

    alu_add #(.W(WORD_W), .HBIT(HALF_B)) u_add_word (
        .a   (opnd_a),
        .b   (opnd_b),
        .cin (carry_use),
        .sum (w_sum),
        .fl  (w_fl)
    );

    alu_dadj #(.W(BYTE_W)) u_dadj (
        .acc  (opnd_a[BYTE_W-1:0]),
        .h_in (h_flag_in),
        .c_in (c_flag_in),
        .res  (d_res),
        .fl   (d_fl)
    );

    always_comb begin
        if (op == OP_DADJ) begin
            mux_res = {{BYTE_W{1'b0}}, d_res};
            mux_fl  = d_fl;
        end else if (wide_sel) begin
            mux_res  = w_sum;
            mux_fl   = w_fl;
            mux_fl.h = h_flag_in;
        end else begin
            mux_res = {{BYTE_W{1'b0}}, n_sum};
            mux_fl  = n_fl;
        end
    end

    alu_outreg #(.W(WORD_W)) u_outreg (
        .clk   (clk),
        .rst   (rst),
        .vld_d (in_valid),
        .res_d (mux_res),
        .fl_d  (mux_fl),
        .vld_q (out_valid),
        .res_q (result),
        .fl_q  (q_fl)
    );

    assign flag_h = q_fl.h;
    assign flag_n = q_fl.n;
    assign flag_z = q_fl.z;
    assign flag_v = q_fl.v;
    assign flag_c = q_fl.c;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [1:0]          op_sel,
    input logic                wide_sel,
    input logic [2*BYTE_W-1:0] opnd_a,
    input logic [2*BYTE_W-1:0] opnd_b,
    input logic                h_flag_in,
    input logic                c_flag_in,
    input logic                out_valid,
    input logic [2*BYTE_W-1:0] result,
    input logic                flag_h,
    input logic                flag_n,
    input logic                flag_z,
    input logic                flag_v,
    input logic                flag_c
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] add_low;
    assign add_low = opnd_a[BYTE_W-1:0] + opnd_b[BYTE_W-1:0];

    // R1
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_follows_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    p_plain_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b00 && !wide_sel) |=>
        (result[BYTE_W-1:0] == $past(add_low)));

    // R4
    p_word_h_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide_sel && op_sel != 2'b10) |=> (flag_h == $past(h_flag_in)));

    // R6
    p_zero_tracks_result_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_z == (result == '0)));
    p_byte_upper_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_sel) |=> (result[WORD_W-1:BYTE_W] == '0));

    // R10
    p_dadj_carry_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b10 && c_flag_in) |=> flag_c);
    p_dadj_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b10) |=> !flag_v);

endmodule

bind alu_core alu_core_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .wide_sel  (wide_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .h_flag_in (h_flag_in),
    .c_flag_in (c_flag_in),
    .out_valid (out_valid),
    .result    (result),
    .flag_h    (flag_h),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c)
);

// File: tb/test_alu_core.sv
module test_alu_core;

    typedef struct {
        logic [15:0] res;
        logic        h, n, z, v, c;
        string       t_res, t_c, t_h, t_v, t_nz;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic        wide_sel = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic        h_flag_in = 1'b0;
    logic        c_flag_in = 1'b0;
    logic        out_valid;
    logic [15:0] result;
    logic        flag_h, flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    alu_core i_alu_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .wide_sel(wide_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .h_flag_in(h_flag_in), .c_flag_in(c_flag_in),
        .out_valid(out_valid), .result(result),
        .flag_h(flag_h), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [1:0] op, input logic wide,
                                   input logic [15:0] a, input logic [15:0] b,
                                   input logic hin, input logic cin);
        exp_t e;
        int   s, cy, lo, hi, corr;
        if (op == 2'b10) begin
            lo = int'(a[3:0]);
            hi = int'(a[7:4]);
            corr = 0;
            if (lo > 9 || hin) corr += 6;
            if (hi > 9 || cin || (hi > 8 && lo > 9)) corr += 'h60;
            s = int'(a[7:0]) + corr;
            e.res = {8'h00, 8'(s)};
            e.c = (s > 255) || cin;
            e.h = hin;
            e.v = 1'b0;
            e.n = e.res[7];
            e.z = (e.res == 16'h0);
            e.t_res = "R8/R9"; e.t_c = "R10"; e.t_h = "R10"; e.t_v = "R10"; e.t_nz = "R10";
        end else begin
            cy = (op == 2'b01 && cin) ? 1 : 0;
            if (wide) begin
                s = int'(a) + int'(b) + cy;
                e.res = 16'(s);
                e.c = s > 65535;
                e.h = hin;
                e.v = (a[15] == b[15]) && (e.res[15] != a[15]);
                e.n = e.res[15];
                e.z = (e.res == 16'h0);
                e.t_res = "R7"; e.t_c = "R7";
            end else begin
                s = int'(a[7:0]) + int'(b[7:0]) + cy;
                e.res = {8'h00, 8'(s)};
                e.c = s > 255;
                e.h = (int'(a[3:0]) + int'(b[3:0]) + cy) > 15;
                e.v = (a[7] == b[7]) && (e.res[7] != a[7]);
                e.n = e.res[7];
                e.z = (e.res[7:0] == 8'h0);
                e.t_res = (op == 2'b01) ? "R3" : "R2";
                e.t_c   = (op == 2'b01) ? "R3" : "R2";
            end
            e.t_h = "R4"; e.t_v = "R5"; e.t_nz = "R6";
        end
        return e;
    endfunction

    task automatic drive(input logic [1:0] op, input logic wide,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic hin, input logic cin);
        @(negedge clk);
        op_sel = op; wide_sel = wide; opnd_a = a; opnd_b = b;
        h_flag_in = hin; c_flag_in = cin; in_valid = 1'b1;
        sb.push_back(model(op, wide, a, b, hin, cin));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check("R1", "unexpected out_valid", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.t_res, "result", result, e.res);
                check(e.t_c, "flag_c", {15'd0, flag_c}, {15'd0, e.c});
                check(e.t_h, "flag_h", {15'd0, flag_h}, {15'd0, e.h});
                check(e.t_v, "flag_v", {15'd0, flag_v}, {15'd0, e.v});
                check(e.t_nz, "flag_n", {15'd0, flag_n}, {15'd0, e.n});
                check(e.t_nz, "flag_z", {15'd0, flag_z}, {15'd0, e.z});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset out_valid", {15'd0, out_valid}, 16'd0);
        check("R1", "reset result", result, 16'd0);
        check("R1", "reset flags", {11'd0, flag_h, flag_n, flag_z, flag_v, flag_c}, 16'd0);
        rst = 1'b0;
        idle(2);
        check("R1", "idle out_valid", {15'd0, out_valid}, 16'd0);

        // R3 exhaustive byte add-with-carry, both carries, junk in upper bytes
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    drive(2'b01, 1'b0, {8'h5A, 8'(a)}, {8'hC3, 8'(b)}, 1'(b & 1), 1'(c));

        // R2 plain add ignores carry; spare code behaves the same
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 7)
                drive((a & 1) ? 2'b11 : 2'b00, 1'b0, 16'(a), 16'(b), 1'b0, 1'b1);

        // R8 R9 R10 BCD correction over every accumulator value and flag pair
        for (int f = 0; f < 4; f++)
            for (int a = 0; a < 256; a++)
                drive(2'b10, 1'(a & 1), {8'hFF, 8'(a)}, 16'(a * 37), 1'(f & 1), 1'(f >> 1));

        // R7 R5 word boundaries
        drive(2'b00, 1'b1, 16'h7FFF, 16'h0001, 1'b0, 1'b0);
        drive(2'b00, 1'b1, 16'hFFFF, 16'h0001, 1'b1, 1'b1);
        drive(2'b00, 1'b1, 16'h8000, 16'h8000, 1'b0, 1'b0);
        drive(2'b01, 1'b1, 16'hFFFF, 16'h0000, 1'b1, 1'b1);
        drive(2'b01, 1'b1, 16'h7FFF, 16'h0000, 1'b0, 1'b1);
        drive(2'b00, 1'b1, 16'h0FFF, 16'h0001, 1'b0, 1'b0);
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] b2;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b2 = {lfsr[7:0], lfsr[15:8]} ^ 16'(i);
            drive(2'(i % 2), 1'b1, lfsr, b2, 1'(i >> 1), 1'(i >> 2));
        end

        // R1 gap between requests
        idle(3);
        check("R1", "out_valid after gap", {15'd0, out_valid}, 16'd0);
        drive(2'b00, 1'b0, 16'h0080, 16'h0080, 1'b0, 1'b0);
        idle(3);
        check("R1", "scoreboard drained", 16'(sb.size()), 16'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule